// File: doc/BRIEF.md
# Ultra DMA Host Burst Terminator

This block is the host-side sequencer that brings an inbound Ultra DMA burst on a 16-bit parallel drive bus to an orderly close. A local start pulse opens a transfer window, in which the block holds the device acknowledge and the host-ready signals asserted. While the window is open it captures each data word that the device marks with a change of the synchronized strobe, and it folds every captured word into a running 16-bit CRC. A local stop pulse asks for the burst to end.

The close proceeds in fixed order, and each step waits out a minimum delay counted in clock cycles. The host first withdraws its ready signal. During the pause that follows it still accepts the words already in flight. It then raises STOP. Once the device has dropped its request it drives the CRC onto the bus. It releases the acknowledge only after the last handshake conditions have held long enough, and it keeps STOP and the withdrawn ready in place for a hold time. When the sequence has finished it reports the number of trailing words with a one-cycle done pulse. A trailing count above what the active transfer mode allows sets a sticky error.

Top module: `udma_host_term`

## Requirements
- R1: A stop request made before any word of the current burst has been captured is remembered. `hdmardy_n_o` rises 2 cycles after the input cycle that carries the first strobe change. A stop request made after a word has been captured raises `hdmardy_n_o` 1 cycle after the request cycle.
- R2: From the cycle `hdmardy_n_o` rises until the block is idle again, `hdmardy_n_o` stays 1. `stop_o` is never 1 while `hdmardy_n_o` is 0.
- R3: Strobe changes seen while `hdmardy_n_o` is 1 and `stop_o` is 0 are captured as trailing words and counted. The count is on `trail_cnt_o` in the done cycle. The limit is 2 for `udma_mode_i` values 0 to 2 and 3 for values 3 and up. A count above the limit sets `proto_err_o`, which stays 1 until reset.
- R4: `stop_o` rises exactly T_RP cycles after `hdmardy_n_o` rises. It stays 1 until the block returns to idle.
- R5: Once `stop_o` is 1, strobe changes are not captured. They give no `word_valid_o` pulse and leave the CRC unchanged.
- R6: `data_oe_o` rises exactly T_ZAH cycles after the first input cycle in which `dmarq_i` is 0 while `stop_o` is 1. In the same cycle `data_o` carries the CRC.
- R7: `dmack_n_o` rises at the later of two cycles. The first is T_MLI cycles after the start of an unbroken run of input cycles with `dstrobe_i`=1 and `dmarq_i`=0 while `stop_o` is 1. The second is T_DVS cycles after `data_oe_o` rises.
- R8: `stop_o` falls exactly T_ACK cycles after `dmack_n_o` rises. In that cycle `done_o` is 1 for one cycle and `data_oe_o` is 0.
- R9: The CRC is seeded with 0x4ABA on start. It is updated once per captured word, MSB first, with polynomial 0x1021 (x^16+x^12+x^5+1). Each captured word gives a one-cycle `word_valid_o` pulse with the word on `word_o`.
- R10: After reset the outputs are: `hdmardy_n_o`=1, `dmack_n_o`=1, `stop_o`=0, `data_oe_o`=0, `done_o`=0, `proto_err_o`=0. A stop request while idle has no effect and is not remembered into the next burst. After start, `hdmardy_n_o` and `dmack_n_o` stay 0 while no word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a burst while idle |
| stop_req_i | input | 1 | Local request to end the burst |
| udma_mode_i | input | 3 | Active transfer mode, 0 to 4 |
| dmarq_i | input | 1 | Device request, 1 = asserted |
| dstrobe_i | input | 1 | Synchronized device strobe level |
| bus_data_i | input | 16 | Data bus as seen by the host |
| hdmardy_n_o | output | 1 | Host ready, active low |
| stop_o | output | 1 | STOP, active high |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| data_oe_o | output | 1 | Host drives the data bus |
| data_o | output | 16 | Value driven on the bus (CRC) |
| word_valid_o | output | 1 | One-cycle pulse per captured word |
| word_o | output | 16 | Captured word |
| done_o | output | 1 | One-cycle pulse at end of termination |
| trail_cnt_o | output | TRAIL_W | Trailing words of the last termination |
| proto_err_o | output | 1 | Sticky trailing-count error |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the acknowledge release, which is gated both by the hold window of the four handshake conditions and by the setup time after the CRC drive. The bench raises the strobe either together with the request drop or several cycles after it, so that each gate in turn sets the release cycle, and it checks the exact release cycle against the later of the two bounds. The second pair is the strobe change that raises the strobe after STOP and the capture path. The bench makes that change and then checks that the pulse count and the driven CRC include only the real words.

// File: rtl/udma_term_pkg.sv
package udma_term_pkg;

    localparam logic [15:0] CRC_SEED = 16'h4ABA;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_PAUSE = 3'd2,
        ST_STOP  = 3'd3,
        ST_DRIVE = 3'd4,
        ST_ACK   = 3'd5
    } term_state_e;

    function automatic logic [15:0] crc_fold(input logic [15:0] crc, input logic [15:0] word);
        logic [15:0] acc;
        logic        fb;
        acc = crc;
        for (int b = 15; b >= 0; b--) begin
            fb  = acc[15] ^ word[b];
            acc = {acc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return acc;
    endfunction

endpackage

// File: rtl/udma_strobe_edge.sv
module udma_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = strobe_i;
        edge_o = strobe_i ^ lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/udma_crc_acc.sv
module udma_crc_acc
    import udma_term_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] crc_o
);
    logic [DATA_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear_i)    crc_d = CRC_SEED;
        else if (upd_i) crc_d = crc_fold(crc_q, word_i);
        crc_o = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/udma_word_latch.sv
module udma_word_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] word_o
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] word;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.valid = cap_i;
        if (cap_i) l_d.word = data_i;
        valid_o   = l_q.valid;
        word_o    = l_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end
endmodule

// File: rtl/udma_host_term.sv
module udma_host_term
    import udma_term_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int MODE_W         = 3,
    parameter int TRAIL_W        = 3,
    parameter int T_RP           = 4,
    parameter int T_ZAH          = 3,
    parameter int T_MLI          = 5,
    parameter int T_DVS          = 4,
    parameter int T_ACK          = 6,
    parameter int FAST_MODE_MIN  = 3,
    parameter int TRAIL_MAX_SLOW = 2,
    parameter int TRAIL_MAX_FAST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_req_i,
    input  logic [MODE_W-1:0]  udma_mode_i,
    input  logic               dmarq_i,
    input  logic               dstrobe_i,
    input  logic [DATA_W-1:0]  bus_data_i,
    output logic               hdmardy_n_o,
    output logic               stop_o,
    output logic               dmack_n_o,
    output logic               data_oe_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               word_valid_o,
    output logic [DATA_W-1:0]  word_o,
    output logic               done_o,
    output logic [TRAIL_W-1:0] trail_cnt_o,
    output logic               proto_err_o
);
    localparam int MAX_RZ  = (T_RP > T_ZAH) ? T_RP : T_ZAH;
    localparam int MAX_DA  = (T_DVS > T_ACK) ? T_DVS : T_ACK;
    localparam int MAX_ALL = (MAX_RZ > MAX_DA) ? MAX_RZ : MAX_DA;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);
    localparam int MLI_W   = $clog2(T_MLI + 1);

    localparam logic [CNT_W-1:0]   RP_END   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0]   ZAH_END  = CNT_W'(T_ZAH - 1);
    localparam logic [CNT_W-1:0]   DVS_END  = CNT_W'(T_DVS - 1);
    localparam logic [CNT_W-1:0]   ACK_END  = CNT_W'(T_ACK - 1);
    localparam logic [MLI_W-1:0]   MLI_END  = MLI_W'(T_MLI - 1);
    localparam logic [MODE_W-1:0]  FAST_MIN = MODE_W'(FAST_MODE_MIN);
    localparam logic [TRAIL_W-1:0] LIM_SLOW = TRAIL_W'(TRAIL_MAX_SLOW);
    localparam logic [TRAIL_W-1:0] LIM_FAST = TRAIL_W'(TRAIL_MAX_FAST);

    typedef struct packed {
        term_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [MLI_W-1:0]   mli;
        logic               pend;
        logic               got_word;
        logic [TRAIL_W-1:0] trail;
        logic               err;
        logic               done;
    } term_t;

    term_t s_d, s_q;

    logic               strobe_edge;
    logic               cap;
    logic               crc_clear;
    logic               hold_ok;
    logic [TRAIL_W-1:0] trail_lim;
    logic [DATA_W-1:0]  crc_val;

    udma_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (dstrobe_i),
        .edge_o   (strobe_edge)
    );

    udma_crc_acc #(.DATA_W(DATA_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .upd_i   (cap),
        .word_i  (bus_data_i),
        .crc_o   (crc_val)
    );

    udma_word_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .data_i  (bus_data_i),
        .valid_o (word_valid_o),
        .word_o  (word_o)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        cap       = strobe_edge && ((s_q.state == ST_XFER) || (s_q.state == ST_PAUSE));
        crc_clear = (s_q.state == ST_IDLE) && start_i;
        hold_ok   = dstrobe_i && !dmarq_i;
        trail_lim = (udma_mode_i >= FAST_MIN) ? LIM_FAST : LIM_SLOW;

        if ((s_q.state == ST_STOP) || (s_q.state == ST_DRIVE)) begin
            if (!hold_ok)                   s_d.mli = '0;
            else if (s_q.mli != {MLI_W{1'b1}}) s_d.mli = s_q.mli + 1'b1;
        end

        case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state    = ST_XFER;
                    s_d.pend     = 1'b0;
                    s_d.got_word = 1'b0;
                    s_d.trail    = '0;
                    s_d.cnt      = '0;
                    s_d.mli      = '0;
                end
            end
            ST_XFER: begin
                if (cap)        s_d.got_word = 1'b1;
                if (stop_req_i) s_d.pend     = 1'b1;
                if ((s_q.pend || stop_req_i) && s_q.got_word) begin
                    s_d.state = ST_PAUSE;
                    s_d.pend  = 1'b0;
                    s_d.cnt   = '0;
                end
            end
            ST_PAUSE: begin
                if (cap && (s_q.trail != {TRAIL_W{1'b1}})) s_d.trail = s_q.trail + 1'b1;
                if (s_q.cnt == RP_END) begin
                    s_d.state = ST_STOP;
                    s_d.cnt   = '0;
                    s_d.mli   = '0;
                    if (s_d.trail > trail_lim) s_d.err = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (dmarq_i) begin
                    s_d.cnt = '0;
                end else if (s_q.cnt == ZAH_END) begin
                    s_d.state = ST_DRIVE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DRIVE: begin
                if (s_q.cnt != {CNT_W{1'b1}}) s_d.cnt = s_q.cnt + 1'b1;
                if (hold_ok && (s_q.mli >= MLI_END) && (s_q.cnt >= DVS_END)) begin
                    s_d.state = ST_ACK;
                    s_d.cnt   = '0;
                end
            end
            ST_ACK: begin
                if (s_q.cnt == ACK_END) begin
                    s_d.state = ST_IDLE;
                    s_d.cnt   = '0;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        hdmardy_n_o = (s_q.state != ST_XFER);
        stop_o      = (s_q.state == ST_STOP) || (s_q.state == ST_DRIVE) || (s_q.state == ST_ACK);
        dmack_n_o   = (s_q.state == ST_IDLE) || (s_q.state == ST_ACK);
        data_oe_o   = (s_q.state == ST_DRIVE) || (s_q.state == ST_ACK);
        data_o      = crc_val;
        done_o      = s_q.done;
        trail_cnt_o = s_q.trail;
        proto_err_o = s_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/udma_term_chk.sv
module udma_term_chk #(
    parameter int T_RP  = 4,
    parameter int T_ACK = 6
) (
    input logic clk,
    input logic rst_n,
    input logic dmarq_i,
    input logic dstrobe_i,
    input logic hdmardy_n_o,
    input logic stop_o,
    input logic dmack_n_o,
    input logic data_oe_o,
    input logic word_valid_o,
    input logic done_o
);
    logic [15:0] pause_run;
    logic [15:0] ack_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_run <= '0;
            ack_run   <= '0;
        end else begin
            if (hdmardy_n_o && !dmack_n_o) begin
                if (pause_run != 16'hFFFF) pause_run <= pause_run + 16'd1;
            end else begin
                pause_run <= '0;
            end
            if (dmack_n_o && stop_o) begin
                if (ack_run != 16'hFFFF) ack_run <= ack_run + 16'd1;
            end else begin
                ack_run <= '0;
            end
        end
    end

    AST_READY_WHILE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> hdmardy_n_o); // R2

    AST_STOP_AFTER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |-> (pause_run >= 16'(T_RP))); // R4

    AST_NO_CAPTURE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_o) |-> !word_valid_o); // R5

    AST_DRIVE_AFTER_DMARQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> !$past(dmarq_i)); // R6

    AST_ACK_RELEASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dmack_n_o) |-> $past(stop_o && dstrobe_i && !dmarq_i && data_oe_o)); // R7

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_o) |-> (ack_run >= 16'(T_ACK))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
endmodule

bind udma_host_term udma_term_chk #(.T_RP(T_RP), .T_ACK(T_ACK)) u_term_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dmarq_i      (dmarq_i),
    .dstrobe_i    (dstrobe_i),
    .hdmardy_n_o  (hdmardy_n_o),
    .stop_o       (stop_o),
    .dmack_n_o    (dmack_n_o),
    .data_oe_o    (data_oe_o),
    .word_valid_o (word_valid_o),
    .done_o       (done_o)
);

// File: tb/test_udma_host_term.sv
module test_udma_host_term;
    localparam int T_RP  = 4;
    localparam int T_ZAH = 3;
    localparam int T_MLI = 5;
    localparam int T_DVS = 4;
    localparam int T_ACK = 6;

    typedef struct packed {
        logic       early;
        logic [2:0] mode;
        logic [3:0] nw;
        logic [2:0] nt;
        logic [3:0] sdly;
    } row_t;

    localparam int NROWS = 5;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 3'd4, 4'd3, 3'd3, 4'd0},
        '{1'b1, 3'd2, 4'd1, 3'd2, 4'd4},
        '{1'b0, 3'd0, 4'd4, 3'd0, 4'd4},
        '{1'b0, 3'd3, 4'd5, 3'd1, 4'd2},
        '{1'b0, 3'd1, 4'd2, 3'd3, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop_req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        dmarq = 1'b1;
    logic        strobe = 1'b0;
    logic [15:0] bus_in = 16'h0000;
    logic        hdmardy_n, stop, dmack_n, oe, wvalid, done, perr;
    logic [15:0] data_out, word_out;
    logic [2:0]  trail_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int valid_cnt = 0;
    int done_cnt = 0;
    int oe_cyc, dmack_cyc, stop_fall_cyc, done_cyc;
    int oe_data, done_trail, done_err, done_oe;
    bit in_term = 1'b0;
    bit hrdy_bad = 1'b0;
    bit p_oe = 1'b0, p_dmack = 1'b1, p_stop = 1'b0;
    bit exp_err = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    udma_host_term #(.T_RP(T_RP), .T_ZAH(T_ZAH), .T_MLI(T_MLI), .T_DVS(T_DVS), .T_ACK(T_ACK))
    i_udma_host_term (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_req_i(stop_req),
        .udma_mode_i(mode), .dmarq_i(dmarq), .dstrobe_i(strobe), .bus_data_i(bus_in),
        .hdmardy_n_o(hdmardy_n), .stop_o(stop), .dmack_n_o(dmack_n), .data_oe_o(oe),
        .data_o(data_out), .word_valid_o(wvalid), .word_o(word_out), .done_o(done),
        .trail_cnt_o(trail_cnt), .proto_err_o(perr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (oe && !p_oe) begin oe_cyc = cyc; oe_data = int'(data_out); end
            if (dmack_n && !p_dmack) dmack_cyc = cyc;
            if (!stop && p_stop) stop_fall_cyc = cyc;
            if (done) begin
                done_cyc = cyc; done_trail = int'(trail_cnt);
                done_err = int'(perr); done_oe = int'(oe); done_cnt++;
            end
            if (wvalid) valid_cnt++;
            if (in_term && !hdmardy_n) hrdy_bad = 1'b1;
            p_oe = oe; p_dmack = dmack_n; p_stop = stop;
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] != w[b]) r = (r << 1) ^ 16'h1021;
            else               r = r << 1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_burst(input int k, input bit early, input int md, input int nw,
                             input int nt, input int sdly);
        logic [15:0] ecrc = 16'h4ABA;
        logic [15:0] w;
        int h_exp, h, st, d, c, dc0, lim, dm_exp;
        mode = 3'(md);
        valid_cnt = 0;
        hrdy_bad = 1'b0;
        dc0 = done_cnt;
        @(negedge clk); dmarq = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 ready held with no words", int'(hdmardy_n), 0);
        chk("R10 ack held with no words", int'(dmack_n), 0);
        if (early) begin
            @(negedge clk); stop_req = 1'b1;
            @(negedge clk); stop_req = 1'b0;
            repeat (3) @(negedge clk);
            chk("R1 stop pending before first word", int'(hdmardy_n), 0);
            @(negedge clk);
            w = 16'(16'hA500 + k * 37); bus_in = w; strobe = ~strobe; ecrc = ref_crc(ecrc, w);
            h_exp = cyc + 2;
            @(negedge clk);
            chk("R1 ready still asserted one cycle after word", int'(hdmardy_n), 0);
        end else begin
            for (int i = 0; i < nw; i++) begin
                @(negedge clk);
                w = 16'(16'hA500 + k * 37 + i * 291); bus_in = w; strobe = ~strobe;
                ecrc = ref_crc(ecrc, w);
                @(negedge clk);
            end
            repeat (2) @(negedge clk);
            stop_req = 1'b1; h_exp = cyc + 1;
            @(negedge clk); stop_req = 1'b0;
        end
        while (hdmardy_n == 1'b0) @(negedge clk);
        h = cyc;
        in_term = 1'b1;
        chk("R1 ready negation cycle", h, h_exp);
        for (int j = 0; j < nt; j++) begin
            w = 16'(16'h3C00 + k * 11 + j); bus_in = w; strobe = ~strobe; ecrc = ref_crc(ecrc, w);
            @(negedge clk);
        end
        while (!stop) @(negedge clk);
        st = cyc;
        chk("R4 stop delay after ready negation", st - h, T_RP);
        repeat (2) @(negedge clk);
        d = cyc; dmarq = 1'b0; c = d;
        if (strobe == 1'b0) begin
            if (sdly == 0) strobe = 1'b1;
            else begin
                repeat (sdly) @(negedge clk);
                strobe = 1'b1; c = d + sdly;
            end
        end
        while (done_cnt == dc0) @(negedge clk);
        @(negedge clk);
        chk("R8 done is a single pulse", int'(done), 0);
        lim = (md >= 3) ? 3 : 2;
        if (nt > lim) exp_err = 1'b1;
        dm_exp = (c + T_MLI > d + T_ZAH + T_DVS) ? c + T_MLI : d + T_ZAH + T_DVS;
        chk("R6 bus drive delay after request drop", oe_cyc - d, T_ZAH);
        chk("R9 crc on bus", oe_data, int'(ecrc));
        chk("R7 ack release cycle", dmack_cyc, dm_exp);
        chk("R8 stop hold after ack release", stop_fall_cyc - dmack_cyc, T_ACK);
        chk("R8 done with stop release", done_cyc, stop_fall_cyc);
        chk("R8 bus released at done", done_oe, 0);
        chk("R3 trailing count", done_trail, nt);
        chk("R3 protocol error flag", done_err, int'(exp_err));
        chk("R5 captured words exclude strobe raise", valid_cnt, nw + nt);
        chk("R2 ready stayed negated", int'(hrdy_bad), 0);
        in_term = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", int'(hdmardy_n), 1);
        chk("R10 reset ack", int'(dmack_n), 1);
        chk("R10 reset stop", int'(stop), 0);
        chk("R10 reset bus", int'(oe), 0);
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset error", int'(perr), 0);
        chk("R9 reset valid", int'(wvalid), 0);

        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 idle stop ignored ready", int'(hdmardy_n), 1);
        chk("R10 idle stop ignored stop", int'(stop), 0);

        for (int r = 0; r < NROWS; r++)
            run_burst(r, ROWS[r].early, int'(ROWS[r].mode), int'(ROWS[r].nw),
                      int'(ROWS[r].nt), int'(ROWS[r].sdly));

        run_burst(9, 1'b0, 4, 2, 1, 0);
        chk("R3 error sticky after clean burst", int'(perr), 1);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; exp_err = 1'b0;
        @(negedge clk);
        chk("R3 error cleared by reset", int'(perr), 0);
        chk("R10 ready after second reset", int'(hdmardy_n), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule